// File: doc/BRIEF.md
# Interleaved Phase Compare Timer

This block is an up-counting period timer with three compare channels. The compare channels can be recomputed automatically as fractions of the period. Software writes a period, three compare values, a control word and an output routing word through a simple register write port. The counter runs from zero up to the active period and wraps, and it emits a single-cycle event on each wrap and on each compare match.

A control word selects the phase arrangement: dual (half period), triple (thirds) or quad (quarters). In those arrangements, the block replaces the active compare values with the matching fractions of the period. The software copies of the compare registers keep whatever software wrote. A preload bit decides when the new values reach the active registers. When the bit is clear, they arrive on the next cycle. When the bit is set, they arrive only after an update pulse.

A set/reset output stage drives one waveform. It uses the period and compare events chosen by the routing word, so a compare-1/period pairing gives a 50% square wave in dual mode. The compare events are also exported so that neighbouring timers can use them as reset sources. A flag warns when dual mode runs with a period shorter than the safe minimum.

Top module: `ilt_timer`

## Requirements
- R1: Register addresses, with all registers cleared to 0 by reset:
  - 0: period.
  - 1, 2, 3: compare 1, 2 and 3.
  - 4: control. Bit 0 is dual, bits 2:1 are the interleave field, bit 3 is preload.
  - 5: routing. Bits 3:0 are set sources and bits 7:4 are reset sources. In each nibble, bit 0 is the period event and bits 1..3 are compare 1..3.

  `rd_data` returns the stored value of the register addressed by `rd_addr`.
- R2: Automatic recomputation never changes the software compare registers. A read returns exactly what software last wrote.
- R3: The counter counts from 0 up to the active period P and then wraps to 0. `per_evt` is high in the cycle where the count equals P, so wrap events are P+1 cycles apart. `cmp_evt[i]` is high in the cycle where the count equals active compare i+1.
- R4: Dual mode (control bit 0 = 1, any interleave field) makes active compare 1 equal to floor(P/2). Compares 2 and 3 take the written values.
- R5: Triple mode (bit 0 = 0, field = 01) makes active compare 1 equal to floor(P/3) and active compare 2 equal to floor(2P/3). Compare 3 takes the written value.
- R6: Quad mode (bit 0 = 0, field = 10) makes the active compares floor(P/4), floor(P/2) and floor(3P/4).
- R7: Disabled mode (field 00) and the reserved field value 11 both use the written compare values unchanged.
- R8: With preload clear, the active period and compares take new values on the cycle after a register write. With preload set, they change only on the cycle after an `upd_evt` pulse.
- R9: `out_wave` is a register. It goes high on the cycle after a routed set-source event and low on the cycle after a routed reset-source event. This gives a square wave in either polarity.
- R10: When set and reset sources fire in the same cycle, the output goes low.
- R11: `per_short` is high while dual mode is selected and the active period is below MIN_HALF_PER (default 192).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | CW | Write data |
| upd_evt | input | 1 | Update pulse that transfers preloaded values |
| rd_addr | input | 3 | Read address |
| rd_data | output | CW | Stored value of the addressed register |
| out_wave | output | 1 | Set/reset output waveform |
| per_evt | output | 1 | Period (wrap) event |
| cmp_evt | output | 3 | Compare 1..3 events |
| per_short | output | 1 | Dual-mode period below minimum |

## Verification
The checker watches several properties on every cycle:
- the counter returns to zero after each period event;
- the output follows the set and reset hits, with reset taking priority;
- the active period holds still while preload waits for an update;
- the software compare register holds still unless it is written.

The divide results for each mode can only be shown by the bench's scenarios. The bench measures compare-event timing against the period event, so truncation and the reserved encoding are seen at the ports. The same applies to the delayed transfer under preload, the duty cycle of both square-wave polarities, and the short-period flag.

// File: rtl/ilt_pkg.sv
package ilt_pkg;

    localparam int NCMP = 3;

    localparam logic [2:0] ADDR_PER   = 3'd0;
    localparam logic [2:0] ADDR_CMP1  = 3'd1;
    localparam logic [2:0] ADDR_CMP2  = 3'd2;
    localparam logic [2:0] ADDR_CMP3  = 3'd3;
    localparam logic [2:0] ADDR_CTRL  = 3'd4;
    localparam logic [2:0] ADDR_ROUTE = 3'd5;

    typedef enum logic [1:0] {
        MODE_OFF,
        MODE_DUAL,
        MODE_TRIPLE,
        MODE_QUAD
    } ilv_mode_e;

    // bit0 dual, bits2:1 interleave field, bit3 preload
    typedef struct packed {
        logic       preload;
        logic [1:0] ilv;
        logic       dual;
    } ctrl_t;

    // bits3:0 set sources, bits7:4 reset sources; bit0 period, bits1..3 compares
    typedef struct packed {
        logic [NCMP:0] rst_mask;
        logic [NCMP:0] set_mask;
    } route_t;

    function automatic ilv_mode_e decode_mode(ctrl_t c);
        if (c.dual)             return MODE_DUAL;
        else if (c.ilv == 2'b01) return MODE_TRIPLE;
        else if (c.ilv == 2'b10) return MODE_QUAD;
        else                     return MODE_OFF;
    endfunction

endpackage

// File: rtl/ilt_regs.sv
module ilt_regs
    import ilt_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [2:0]               wr_addr,
    input  logic [CW-1:0]            wr_data,
    input  logic                     upd_evt,
    input  logic [2:0]               rd_addr,
    output logic [CW-1:0]            rd_data,
    output ctrl_t                    ctrl,
    output route_t                   route,
    output logic [NCMP-1:0][CW-1:0]  cmp_sw,
    output logic [CW-1:0]            per_act,
    output logic [NCMP-1:0][CW-1:0]  cmp_act
);
    localparam int EW = CW + 2;
    localparam int CTRL_W  = $bits(ctrl_t);
    localparam int ROUTE_W = $bits(route_t);

    logic [CW-1:0]           per_sw;
    logic [NCMP-1:0][CW-1:0] cmp_calc;
    logic [EW-1:0]           p_ext;
    logic [EW-1:0]           p_x2;
    logic [EW-1:0]           p_x3;
    ilv_mode_e               mode;
    logic                    load_act;

    // software-visible registers
    always_ff @(posedge clk) begin
        if (rst) begin
            per_sw <= '0;
            cmp_sw <= '0;
            ctrl   <= '0;
            route  <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_PER:   per_sw    <= wr_data;
                ADDR_CMP1:  cmp_sw[0] <= wr_data;
                ADDR_CMP2:  cmp_sw[1] <= wr_data;
                ADDR_CMP3:  cmp_sw[2] <= wr_data;
                ADDR_CTRL:  ctrl      <= ctrl_t'(wr_data[CTRL_W-1:0]);
                ADDR_ROUTE: route     <= route_t'(wr_data[ROUTE_W-1:0]);
                default: ;
            endcase
        end
    end

    always_comb begin
        case (rd_addr)
            ADDR_PER:   rd_data = per_sw;
            ADDR_CMP1:  rd_data = cmp_sw[0];
            ADDR_CMP2:  rd_data = cmp_sw[1];
            ADDR_CMP3:  rd_data = cmp_sw[2];
            ADDR_CTRL:  rd_data = CW'(ctrl);
            ADDR_ROUTE: rd_data = CW'(route);
            default:    rd_data = '0;
        endcase
    end

    // fractional recomputation
    assign mode  = decode_mode(ctrl);
    assign p_ext = EW'(per_sw);
    assign p_x2  = p_ext << 1;
    assign p_x3  = p_ext + p_x2;

    always_comb begin
        cmp_calc = cmp_sw;
        case (mode)
            MODE_DUAL: begin
                cmp_calc[0] = per_sw >> 1;
            end
            MODE_TRIPLE: begin
                cmp_calc[0] = CW'(p_ext / EW'(3));
                cmp_calc[1] = CW'(p_x2 / EW'(3));
            end
            MODE_QUAD: begin
                cmp_calc[0] = per_sw >> 2;
                cmp_calc[1] = per_sw >> 1;
                cmp_calc[2] = CW'(p_x3 >> 2);
            end
            default: ;
        endcase
    end

    // active registers
    assign load_act = ctrl.preload ? upd_evt : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            per_act <= '0;
            cmp_act <= '0;
        end else if (load_act) begin
            per_act <= per_sw;
            cmp_act <= cmp_calc;
        end
    end

endmodule

// File: rtl/ilt_counter.sv
module ilt_counter
    import ilt_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [CW-1:0]           per_act,
    input  logic [NCMP-1:0][CW-1:0] cmp_act,
    output logic [CW-1:0]           cnt,
    output logic                    per_evt,
    output logic [NCMP-1:0]         cmp_evt
);
    always_ff @(posedge clk) begin
        if (rst)                 cnt <= '0;
        else if (cnt >= per_act) cnt <= '0;
        else                     cnt <= cnt + 1'b1;
    end

    assign per_evt = (cnt == per_act);

    for (genvar i = 0; i < NCMP; i++) begin : g_cmp
        assign cmp_evt[i] = (cnt == cmp_act[i]);
    end

endmodule

// File: rtl/ilt_outstage.sv
module ilt_outstage
    import ilt_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  route_t          route,
    input  logic            per_evt,
    input  logic [NCMP-1:0] cmp_evt,
    output logic            set_hit,
    output logic            rst_hit,
    output logic            out_wave
);
    logic [NCMP:0] evs;

    assign evs     = {cmp_evt, per_evt};
    assign set_hit = |(evs & route.set_mask);
    assign rst_hit = |(evs & route.rst_mask);

    always_ff @(posedge clk) begin
        if (rst)          out_wave <= 1'b0;
        else if (rst_hit) out_wave <= 1'b0;
        else if (set_hit) out_wave <= 1'b1;
    end

endmodule

// File: rtl/ilt_timer.sv
module ilt_timer
    import ilt_pkg::*;
#(
    parameter int CW           = 16,
    parameter int MIN_HALF_PER = 192
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [2:0]      wr_addr,
    input  logic [CW-1:0]   wr_data,
    input  logic            upd_evt,
    input  logic [2:0]      rd_addr,
    output logic [CW-1:0]   rd_data,
    output logic            out_wave,
    output logic            per_evt,
    output logic [NCMP-1:0] cmp_evt,
    output logic            per_short
);
    ctrl_t                   ctrl;
    route_t                  route;
    logic [NCMP-1:0][CW-1:0] cmp_sw;
    logic [CW-1:0]           per_act;
    logic [NCMP-1:0][CW-1:0] cmp_act;
    logic [CW-1:0]           cnt;
    logic                    set_hit;
    logic                    rst_hit;

    ilt_regs #(.CW(CW)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .upd_evt(upd_evt), .rd_addr(rd_addr),
        .rd_data(rd_data), .ctrl(ctrl), .route(route), .cmp_sw(cmp_sw),
        .per_act(per_act), .cmp_act(cmp_act)
    );

    ilt_counter #(.CW(CW)) u_cnt (
        .clk(clk), .rst(rst), .per_act(per_act), .cmp_act(cmp_act),
        .cnt(cnt), .per_evt(per_evt), .cmp_evt(cmp_evt)
    );

    ilt_outstage u_out (
        .clk(clk), .rst(rst), .route(route), .per_evt(per_evt),
        .cmp_evt(cmp_evt), .set_hit(set_hit), .rst_hit(rst_hit),
        .out_wave(out_wave)
    );

    assign per_short = ctrl.dual && (per_act < CW'(MIN_HALF_PER));

endmodule

// File: rtl/ilt_timer_chk.sv
module ilt_timer_chk
    import ilt_pkg::*;
#(
    parameter int CW = 16
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    wr_en,
    input logic [2:0]              wr_addr,
    input logic                    upd_evt,
    input ctrl_t                   ctrl,
    input logic [NCMP-1:0][CW-1:0] cmp_sw,
    input logic [CW-1:0]           per_act,
    input logic [CW-1:0]           cnt,
    input logic                    per_evt,
    input logic                    set_hit,
    input logic                    rst_hit,
    input logic                    out_wave
);
    // R2
    cmp1_sw_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_addr == ADDR_CMP1) |=> $stable(cmp_sw[0]));

    // R3
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
        per_evt |=> (cnt == '0));

    // R8
    preload_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.preload && !upd_evt) |=> $stable(per_act));

    // R9
    set_drives_high_chk: assert property (@(posedge clk) disable iff (rst)
        (set_hit && !rst_hit) |=> out_wave);

    // R10
    reset_wins_chk: assert property (@(posedge clk) disable iff (rst)
        rst_hit |=> !out_wave);

endmodule

bind ilt_timer ilt_timer_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .upd_evt(upd_evt), .ctrl(ctrl), .cmp_sw(cmp_sw), .per_act(per_act),
    .cnt(cnt), .per_evt(per_evt), .set_hit(set_hit), .rst_hit(rst_hit),
    .out_wave(out_wave)
);

// File: tb/tb_ilt_timer.sv
module tb_ilt_timer;
    localparam int CW = 16;
    localparam int NV = 10;
    localparam int LIMIT = 1000;

    logic          clk = 1'b0;
    logic          rst;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_addr = '0;
    logic [CW-1:0] wr_data = '0;
    logic          upd_evt = 1'b0;
    logic [2:0]    rd_addr = '0;
    logic [CW-1:0] rd_data;
    logic          out_wave;
    logic          per_evt;
    logic [2:0]    cmp_evt;
    logic          per_short;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk; // 125 MHz

    ilt_timer dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .upd_evt(upd_evt), .rd_addr(rd_addr),
        .rd_data(rd_data), .out_wave(out_wave), .per_evt(per_evt),
        .cmp_evt(cmp_evt), .per_short(per_short)
    );

    // ctrl, period, sw cmp1..3, expected active cmp1..3, expected short flag
    localparam int VEC [NV][9] = '{
        '{0,  100, 10, 20, 30,  10,  20, 30, 0},  // R7 off
        '{1,  200, 10, 20, 30, 100,  20, 30, 0},  // R4 dual
        '{1,  201, 11, 21, 31, 100,  21, 31, 0},  // R4 truncation
        '{2,  100, 10, 20, 30,  33,  66, 30, 0},  // R5 triple
        '{2,  200, 10, 20, 30,  66, 133, 30, 0},  // R5 triple
        '{4,  100, 10, 20, 30,  25,  50, 75, 0},  // R6 quad
        '{4,  102, 10, 20, 30,  25,  51, 76, 0},  // R6 truncation
        '{6,  100, 12, 22, 32,  12,  22, 32, 0},  // R7 reserved
        '{5,  200, 10, 20, 30, 100,  20, 30, 0},  // R4 dual ignores field
        '{1,  100, 10, 20, 30,  50,  20, 30, 1}   // R11 short period
    };

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = CW'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // cycles between wraps minus one gives the active period
    task automatic meas_per(output int v);
        int n;
        v = -1;
        for (int k = 0; k < LIMIT; k++) begin
            @(negedge clk);
            if (per_evt) break;
        end
        n = 0;
        for (int k = 0; k < LIMIT; k++) begin
            @(negedge clk);
            n++;
            if (per_evt) begin v = n - 1; break; end
        end
    endtask

    // cycles from a wrap to compare event i, minus one, gives active compare
    task automatic meas_cmp(int i, output int v);
        v = -1;
        for (int k = 0; k < LIMIT; k++) begin
            @(negedge clk);
            if (per_evt) break;
        end
        for (int k = 1; k < LIMIT; k++) begin
            @(negedge clk);
            if (cmp_evt[i]) begin v = k - 1; break; end
        end
    endtask

    task automatic meas_duty(output int hi, output int lo);
        hi = 0; lo = 0;
        for (int k = 0; k < LIMIT; k++) begin @(negedge clk); if (!out_wave) break; end
        for (int k = 0; k < LIMIT; k++) begin @(negedge clk); if (out_wave) break; end
        for (int k = 0; k < LIMIT; k++) begin
            if (!out_wave) break;
            hi++; @(negedge clk);
        end
        for (int k = 0; k < LIMIT; k++) begin
            if (out_wave) break;
            lo++; @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int v, hi, lo;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // reset state
        rd_addr = 3'd0; #1 check("R1 period reset", int'(rd_data), 0);
        rd_addr = 3'd4; #1 check("R1 ctrl reset", int'(rd_data), 0);
        check("R9 out reset", int'(out_wave), 0);
        check("R11 flag reset", int'(per_short), 0);

        // table walk, preload off
        for (int i = 0; i < NV; i++) begin
            wr(3'd4, VEC[i][0]);
            wr(3'd1, VEC[i][2]);
            wr(3'd2, VEC[i][3]);
            wr(3'd3, VEC[i][4]);
            wr(3'd0, VEC[i][1]);
            @(negedge clk);
            meas_per(v);  check("R3 period", v, VEC[i][1]);
            meas_cmp(0, v); check("R4/R5/R6/R7 cmp1", v, VEC[i][5]);
            meas_cmp(1, v); check("R5/R6/R7 cmp2", v, VEC[i][6]);
            meas_cmp(2, v); check("R6/R7 cmp3", v, VEC[i][7]);
            rd_addr = 3'd1; #1 check("R2 cmp1 readback", int'(rd_data), VEC[i][2]);
            rd_addr = 3'd2; #1 check("R2 cmp2 readback", int'(rd_data), VEC[i][3]);
            rd_addr = 3'd0; #1 check("R1 period readback", int'(rd_data), VEC[i][1]);
            check("R11 short flag", int'(per_short), VEC[i][8]);
        end

        // R9 square wave: set on period, reset on compare 1, dual P=200
        wr(3'd4, 1);
        wr(3'd0, 200);
        wr(3'd5, 8'h21);
        rd_addr = 3'd5; #1 check("R1 route readback", int'(rd_data), 8'h21);
        meas_duty(hi, lo);
        check("R9 high time", hi, 101);
        check("R9 low time", lo, 100);
        // R9 opposite polarity
        wr(3'd5, 8'h12);
        meas_duty(hi, lo);
        check("R9 inv high time", hi, 100);
        check("R9 inv low time", lo, 101);

        // R10 reset wins over set on the same event
        wr(3'd5, 8'h01);
        for (int k = 0; k < LIMIT; k++) begin @(negedge clk); if (out_wave) break; end
        check("R10 output set first", int'(out_wave), 1);
        wr(3'd5, 8'h11);
        repeat (420) @(negedge clk);
        check("R10 reset priority", int'(out_wave), 0);
        wr(3'd5, 0);

        // R8 preload: quad P=100 active, then preload on and P=40
        wr(3'd4, 4);
        wr(3'd0, 100);
        @(negedge clk);
        wr(3'd4, 4 | 8);
        wr(3'd0, 40);
        repeat (5) @(negedge clk);
        meas_per(v);    check("R8 period held", v, 100);
        meas_cmp(0, v); check("R8 cmp1 held", v, 25);
        @(negedge clk); upd_evt = 1'b1;
        @(negedge clk); upd_evt = 1'b0;
        meas_per(v);    check("R8 period after update", v, 40);
        meas_cmp(0, v); check("R8 cmp1 after update", v, 10);
        meas_cmp(2, v); check("R8 cmp3 after update", v, 30);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule